// File: doc/BRIEF.md
# Repeater Source Selection and Collision Arbiter

This block is the forwarding core of a four-port repeater chip that can be cascaded with other chips of its kind. Each clock it looks at which local twisted-pair ports are receiving and which cascaded neighbours report activity. It then decides one of four things: a single local port is the source, the expansion bus is the source, a collision is in progress, or the segment is idle. From that decision it drives the transmit enables and symbols of all four ports, drives the expansion data bus, and pulls the shared collision line low.

Receive activity, receive symbols, the receive-enable mask, the expansion bus symbol, the neighbour activity lines and the shared collision line are all registered on the rising edge. Every forwarding output is decoded from that single register stage, so outputs follow their inputs by exactly one clock. The only exception is the local activity output, which follows the masked port activity without a clock. The jam and idle symbols are fixed codes supplied at the ports.

Top module: `repeater_arbiter`

## Requirements
- R1: `localActN` is low exactly when at least one port has both its `portRxActive` bit and its `portRxEnable` bit at 1; it follows these inputs without a clock.
- R2: When exactly one enabled local port is active and no other source is active, the port outputs change one clock later: every other port has `portTxEn` set and carries that port's receive symbol, and the source port has `portTxEn` clear. Port i uses bits [5i+4:5i] of the symbol vectors.
- R3: `expTxOe` is 1 only in the single-local-source case of R2, and `expTxSym` then carries the source port's symbol; in every other case `expTxOe` is 0 and `expTxSym` holds `idleSym`.
- R4: When no enabled local port is active, exactly one neighbour line of `peerActN` is low, and the collision line is high, all four ports are enabled and carry `expRxSym`.
- R5: When the number of enabled active local ports plus the number of low `peerActN` lines is two or more, all four ports are enabled and carry `jamSym`.
- R6: `colDriveN` is 0 exactly when at least two enabled local ports are active, or at least one is active together with at least one low `peerActN` line. A collision among neighbours alone leaves it at 1.
- R7: A low `colInN` jams all four ports with `jamSym` one clock later, whatever the activity, and does not by itself pull `colDriveN` low.
- R8: A port whose `portRxEnable` bit is 0 counts as inactive in every decision above: it is never a source, never adds to a collision, and does not affect `localActN`.
- R9: After reset, and whenever no source is active and the collision line is high, all `portTxEn` bits are 0, all port symbols are `idleSym`, `expTxOe` is 0 and `colDriveN` is 1.
- R10: Apart from `localActN`, no output changes before the first rising clock edge after an input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz reference clock |
| rstN | input | 1 | Asynchronous reset, active low |
| portRxActive | input | 4 | Per-port receive-active flags |
| portRxSym | input | 20 | Per-port 5-bit receive symbols, port i at [5i+4:5i] |
| portRxEnable | input | 4 | Per-port receive-enable mask (0 = port blocked by fault handling) |
| peerActN | input | 5 | Activity lines from cascaded chips, active low, unused held high |
| colInN | input | 1 | Shared collision line as seen at the pin, active low |
| expRxSym | input | 5 | Symbol received from the expansion bus |
| jamSym | input | 5 | Fixed jam symbol code |
| idleSym | input | 5 | Fixed idle symbol code |
| localActN | output | 1 | Local activity output, active low |
| colDriveN | output | 1 | Pull-down request onto the shared collision line, active low |
| portTxEn | output | 4 | Per-port transmit enables |
| portTxSym | output | 20 | Per-port transmit symbols, port i at [5i+4:5i] |
| expTxSym | output | 5 | Symbol driven onto the expansion bus |
| expTxOe | output | 1 | Output enable for the expansion bus |

## Verification
The hardest case to reach is the boundary between a single source and a collision when the activity is split across the local ports, the neighbour lines and the separate collision line. For example, one local port active while one neighbour line is low must jam and drive the collision line, but two neighbours alone must jam without driving it. The stimulus sweeps every combination of local activity, receive-enable mask, neighbour activity and collision-line level, one per clock. Each result is compared against a count-based expectation, so every mix of local and remote sources is hit, including the masked ports that must drop out of the count.

// File: rtl/rptr_pkg.sv
package rptr_pkg;
  // Decision strobes from control to datapath; at most one is set.
  typedef struct packed {
    logic jam;       // collision: jam symbol to every port
    logic fwdLocal;  // single local source
    logic fwdExp;    // single remote source on expansion bus
  } rptrStrobes_t;
endpackage

// File: rtl/rptr_sample.sv
module rptr_sample #(
  parameter int NUM_PORTS = 4,
  parameter int NUM_PEERS = 5,
  parameter int SYM_W     = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PORTS-1:0]       portRxActive,
  input  logic [NUM_PORTS*SYM_W-1:0] portRxSym,
  input  logic [NUM_PORTS-1:0]       portRxEnable,
  input  logic [NUM_PEERS-1:0]       peerActN,
  input  logic                       colInN,
  input  logic [SYM_W-1:0]           expRxSym,
  output logic [NUM_PORTS-1:0]       actQ,
  output logic [NUM_PORTS*SYM_W-1:0] symQ,
  output logic [NUM_PEERS-1:0]       peerQ,
  output logic                       colSeenQ,
  output logic [SYM_W-1:0]           expSymQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actQ     <= '0;
      symQ     <= '0;
      peerQ    <= '0;
      colSeenQ <= 1'b0;
      expSymQ  <= '0;
    end else begin
      actQ     <= portRxActive & portRxEnable;
      symQ     <= portRxSym;
      peerQ    <= ~peerActN;
      colSeenQ <= ~colInN;
      expSymQ  <= expRxSym;
    end
  end
endmodule

// File: rtl/rptr_ctrl.sv
module rptr_ctrl
  import rptr_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int NUM_PEERS = 5,
  localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int CNT_W    = $clog2(NUM_PORTS + NUM_PEERS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] actQ,
  input  logic [NUM_PEERS-1:0] peerQ,
  input  logic                 colSeenQ,
  output rptrStrobes_t         strobes,
  output logic [IDX_W-1:0]     srcIdx,
  output logic                 colDriveN
);
  logic [CNT_W-1:0] localCnt;
  logic [CNT_W-1:0] peerCnt;
  logic [CNT_W-1:0] totalCnt;

  always_comb begin
    localCnt = '0;
    srcIdx   = '0;
    for (int i = NUM_PORTS - 1; i >= 0; i--) begin
      if (actQ[i]) begin
        localCnt = localCnt + 1'b1;
        srcIdx   = IDX_W'(i);
      end
    end
    peerCnt = '0;
    for (int j = 0; j < NUM_PEERS; j++) begin
      peerCnt = peerCnt + CNT_W'(peerQ[j]);
    end
    totalCnt = localCnt + peerCnt;
  end

  always_comb begin
    strobes.jam      = (totalCnt >= CNT_W'(2)) || colSeenQ;
    strobes.fwdLocal = !strobes.jam && (localCnt == CNT_W'(1));
    strobes.fwdExp   = !strobes.jam && (localCnt == '0) && (peerCnt == CNT_W'(1));
    colDriveN = !((localCnt >= CNT_W'(2)) ||
                  ((localCnt != '0) && (peerCnt != '0)));
  end

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.jam, strobes.fwdLocal, strobes.fwdExp}));
  // R6
  col_drive_jam_chk: assert property (@(posedge clk) disable iff (!rstN)
    !colDriveN |-> strobes.jam);
  // R8
  src_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fwdLocal |-> (actQ[srcIdx] && $countones(actQ) == 1));
endmodule

// File: rtl/rptr_datapath.sv
module rptr_datapath
  import rptr_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int SYM_W     = 5,
  localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  rptrStrobes_t               strobes,
  input  logic [IDX_W-1:0]           srcIdx,
  input  logic [NUM_PORTS*SYM_W-1:0] symQ,
  input  logic [SYM_W-1:0]           expSymQ,
  input  logic [SYM_W-1:0]           jamSym,
  input  logic [SYM_W-1:0]           idleSym,
  output logic [NUM_PORTS-1:0]       portTxEn,
  output logic [NUM_PORTS*SYM_W-1:0] portTxSym,
  output logic [SYM_W-1:0]           expTxSym,
  output logic                       expTxOe
);
  logic [SYM_W-1:0] srcSym;
  logic [SYM_W-1:0] fanSym;

  always_comb begin
    srcSym = symQ[srcIdx*SYM_W +: SYM_W];
    if (strobes.jam)           fanSym = jamSym;
    else if (strobes.fwdExp)   fanSym = expSymQ;
    else if (strobes.fwdLocal) fanSym = srcSym;
    else                       fanSym = idleSym;
    expTxOe  = strobes.fwdLocal;
    expTxSym = strobes.fwdLocal ? srcSym : idleSym;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_comb begin
      portTxEn[p] = strobes.jam || strobes.fwdExp ||
                    (strobes.fwdLocal && (srcIdx != IDX_W'(p)));
      portTxSym[p*SYM_W +: SYM_W] = fanSym;
    end
  end

  // R3
  oe_fanout_chk: assert property (@(posedge clk) disable iff (!rstN)
    expTxOe |-> ($countones(portTxEn) == NUM_PORTS - 1));
  // R5
  jam_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.jam |-> (&portTxEn && portTxSym[SYM_W-1:0] == jamSym));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (portTxEn == '0) |-> !expTxOe);
endmodule

// File: rtl/repeater_arbiter.sv
module repeater_arbiter
  import rptr_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int NUM_PEERS = 5,
  parameter int SYM_W     = 5,
  localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PORTS-1:0]       portRxActive,
  input  logic [NUM_PORTS*SYM_W-1:0] portRxSym,
  input  logic [NUM_PORTS-1:0]       portRxEnable,
  input  logic [NUM_PEERS-1:0]       peerActN,
  input  logic                       colInN,
  input  logic [SYM_W-1:0]           expRxSym,
  input  logic [SYM_W-1:0]           jamSym,
  input  logic [SYM_W-1:0]           idleSym,
  output logic                       localActN,
  output logic                       colDriveN,
  output logic [NUM_PORTS-1:0]       portTxEn,
  output logic [NUM_PORTS*SYM_W-1:0] portTxSym,
  output logic [SYM_W-1:0]           expTxSym,
  output logic                       expTxOe
);
  logic [NUM_PORTS-1:0]       actQ;
  logic [NUM_PORTS*SYM_W-1:0] symQ;
  logic [NUM_PEERS-1:0]       peerQ;
  logic                       colSeenQ;
  logic [SYM_W-1:0]           expSymQ;
  rptrStrobes_t               strobes;
  logic [IDX_W-1:0]           srcIdx;

  // R1: unclocked local activity indication
  assign localActN = ~|(portRxActive & portRxEnable);

  rptr_sample #(.NUM_PORTS(NUM_PORTS), .NUM_PEERS(NUM_PEERS), .SYM_W(SYM_W)) u_sample (
    .clk(clk), .rstN(rstN), .portRxActive(portRxActive), .portRxSym(portRxSym),
    .portRxEnable(portRxEnable), .peerActN(peerActN), .colInN(colInN),
    .expRxSym(expRxSym), .actQ(actQ), .symQ(symQ), .peerQ(peerQ),
    .colSeenQ(colSeenQ), .expSymQ(expSymQ));

  rptr_ctrl #(.NUM_PORTS(NUM_PORTS), .NUM_PEERS(NUM_PEERS)) u_ctrl (
    .clk(clk), .rstN(rstN), .actQ(actQ), .peerQ(peerQ), .colSeenQ(colSeenQ),
    .strobes(strobes), .srcIdx(srcIdx), .colDriveN(colDriveN));

  rptr_datapath #(.NUM_PORTS(NUM_PORTS), .SYM_W(SYM_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .srcIdx(srcIdx), .symQ(symQ),
    .expSymQ(expSymQ), .jamSym(jamSym), .idleSym(idleSym), .portTxEn(portTxEn),
    .portTxSym(portTxSym), .expTxSym(expTxSym), .expTxOe(expTxOe));

  // R7
  col_in_jam_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!colInN) && $past(rstN) |-> &portTxEn);
endmodule

// File: tb/repeater_arbiter_test.sv
module repeater_arbiter_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  portRxActive = '0;
  logic [19:0] portRxSym = '0;
  logic [3:0]  portRxEnable = '0;
  logic [4:0]  peerActN = 5'h1F;
  logic        colInN = 1'b1;
  logic [4:0]  expRxSym = '0;
  logic [4:0]  jamSym = 5'b00100;
  logic [4:0]  idleSym = 5'b11111;
  logic        localActN, colDriveN, expTxOe;
  logic [3:0]  portTxEn;
  logic [19:0] portTxSym;
  logic [4:0]  expTxSym;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // expected registered outputs for the most recent and the previous stimulus
  logic [3:0]  eEn, pEn;
  logic [19:0] eSym, pSym;
  logic [4:0]  eExpSym, pExpSym;
  logic        eOe, pOe, eCol, pCol;
  string       eTag;

  always #4 clk = ~clk;

  repeater_arbiter uut (
    .clk(clk), .rstN(rstN), .portRxActive(portRxActive), .portRxSym(portRxSym),
    .portRxEnable(portRxEnable), .peerActN(peerActN), .colInN(colInN),
    .expRxSym(expRxSym), .jamSym(jamSym), .idleSym(idleSym),
    .localActN(localActN), .colDriveN(colDriveN), .portTxEn(portTxEn),
    .portTxSym(portTxSym), .expTxSym(expTxSym), .expTxOe(expTxOe));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      if (fails <= 20) $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_for(input logic [3:0] act, input logic [3:0] en,
                            input logic [4:0] pN, input logic cN);
    int lc = 0, pc = 0, src = 0;
    logic [3:0] la = act & en;
    bit jam, fl, fe;
    for (int i = 3; i >= 0; i--) if (la[i]) begin lc++; src = i; end
    for (int j = 0; j < 5; j++) if (!pN[j]) pc++;
    jam = (lc + pc >= 2) || !cN;
    fl  = !jam && lc == 1;
    fe  = !jam && lc == 0 && pc == 1;
    eCol = !((lc >= 2) || (lc >= 1 && pc >= 1));
    eOe = fl;
    eExpSym = fl ? portRxSym[src*5 +: 5] : idleSym;
    for (int i = 0; i < 4; i++) begin
      eEn[i] = jam || fe || (fl && i != src);
      eSym[i*5 +: 5] = jam ? jamSym : fe ? expRxSym : fl ? portRxSym[src*5 +: 5] : idleSym;
    end
    if (jam) eTag = (lc + pc < 2) ? "R7" : "R5";
    else if (fl) eTag = "R2";
    else if (fe) eTag = "R4";
    else eTag = "R9";
    if (en != 4'hF && act != 4'h0) eTag = {eTag, "/R8"};
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(portTxEn == 4'h0, "R9 reset txEn", portTxEn, 0);
    chk(expTxOe == 1'b0, "R9 reset oe", expTxOe, 0);
    chk(colDriveN == 1'b1, "R9 reset colDrive", colDriveN, 1);
    chk(localActN == 1'b1, "R1 reset localAct", localActN, 1);
    rstN = 1'b1;
    @(negedge clk);
    chk(portTxSym == {4{idleSym}}, "R9 idle symbols", portTxSym, {4{idleSym}});
    expect_for(4'h0, 4'h0, 5'h1F, 1'b1);
    for (int en = 0; en < 16; en++)
      for (int a = 0; a < 16; a++)
        for (int p = 0; p < 32; p++)
          for (int c = 0; c < 2; c++) begin
            pEn = eEn; pSym = eSym; pExpSym = eExpSym; pOe = eOe; pCol = eCol;
            portRxActive = 4'(a);
            portRxEnable = 4'(en);
            peerActN = 5'(p);
            colInN = c[0];
            for (int i = 0; i < 4; i++) portRxSym[i*5 +: 5] = 5'((i * 5 + a + p + en) & 31);
            expRxSym = 5'((p * 3 + a + 1) & 31);
            expect_for(4'(a), 4'(en), 5'(p), c[0]);
            #1;
            // R1 / R8: unclocked activity output under the mask
            chk(localActN == !((a & en) != 0), (en != 15) ? "R8 localAct mask" : "R1 localAct",
                localActN, !((a & en) != 0));
            // R10: nothing registered moves before the edge
            chk(portTxEn == pEn && portTxSym == pSym && expTxOe == pOe && colDriveN == pCol,
                "R10 early change", {portTxEn, expTxOe, colDriveN}, {pEn, pOe, pCol});
            @(negedge clk);
            chk(portTxEn == eEn, {eTag, " txEn"}, portTxEn, eEn);
            chk(portTxSym == eSym, {eTag, " txSym"}, portTxSym, eSym);
            chk(expTxOe == eOe && expTxSym == eExpSym, "R3 expansion drive",
                {expTxOe, expTxSym}, {eOe, eExpSym});
            chk(colDriveN == eCol, "R6 collision drive", colDriveN, eCol);
          end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule